// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address for each beat of a four-beat memory burst. A start strobe loads the whole external address, and that address is the first beat. Each advance after that changes only the two least significant bits. The upper bits keep the value captured at load until the next load. When neither a start strobe nor an advance is present, the address holds and the burst is suspended. All control inputs are active high and are sampled on the rising clock edge. The output comes from registered state.

The order of the low bits is chosen by a mode input, which is captured as a configuration level at each load:
- **Linear** order adds one to the low bits and wraps modulo 4.
- **Interleaved** order XORs the starting low bits with a beat count that begins at zero.

There are two independent start strobes, one for the processor side and one for the controller side. Either one alone starts a burst, and both together behave the same as one.

The control core is a three-state machine:
- **IDLE** is the state after reset. No burst has been loaded, and advances are ignored.
- **RUN** means the last cycle moved or loaded the address.
- **HOLD** means the burst is suspended.

Transitions:
- Any state goes to RUN on a start strobe, which reloads the address.
- RUN stays in RUN on an advance.
- RUN goes to HOLD when there is no advance.
- HOLD goes to RUN on an advance.
- HOLD stays in HOLD otherwise.
- IDLE stays in IDLE until a start strobe arrives.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and after it is released, the burst address output is all zeros, and advances are ignored until the first start strobe.
- R2: A start strobe on either `start_cpu_i` or `start_ctl_i`, or on both, makes the output equal to `ext_addr_i` after that clock edge.
- R3: With mode 0 (linear), each advance sets the low two bits to the previous low bits plus one, modulo 4. For example, 01 goes to 10, then 11, then 00.
- R4: With mode 1 (interleaved), the low two bits on beat k are the starting low bits XOR k. For example, a start of 10 gives 10, 11, 00, 01.
- R5: Address bits above bit 1 keep their loaded value for the whole burst. `ext_addr_i` has no effect when no start strobe is present.
- R6: Without an advance or a start strobe, the output holds its value (suspend), and a later advance resumes from that beat.
- R7: When a start strobe and an advance arrive in the same cycle, the load takes effect and the advance is discarded.
- R8: The mode is captured at load. Changing `ilv_mode_i` during a burst does not change the order until the next load.
- R9: After four advances, the low bits return to the starting value in both orders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_cpu_i | input | 1 | Processor-side start strobe, active high |
| start_ctl_i | input | 1 | Controller-side start strobe, active high |
| adv_i | input | 1 | Advance to the next beat, active high |
| ilv_mode_i | input | 1 | Order select: 0 linear, 1 interleaved |
| ext_addr_i | input | ADDR_W | External address captured on a start |
| burst_addr_o | output | ADDR_W | Current burst address |

## Verification
A start strobe and an advance can fall in the same cycle, and so can both start strobes. The stimulus table raises a start together with an advance in the middle of an interleaved burst. The expected output is then the fresh external address, not a stepped value. Later steps are judged from that new start. In a separate case, both strobes are driven together in linear mode, and a single clean load is expected.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int LOW_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_t;

    typedef enum logic {
        ORD_LIN = 1'b0,
        ORD_ILV = 1'b1
    } order_t;

    // Low bits for a given beat of a burst starting at base.
    function automatic logic [LOW_W-1:0] beat_low(
        input logic [LOW_W-1:0] base,
        input logic [LOW_W-1:0] beat,
        input order_t           ord
    );
        logic [LOW_W-1:0] r;
        unique case (ord)
            ORD_LIN: r = base + beat;
            ORD_ILV: r = base ^ beat;
            default: r = base;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_any,
    input  logic       adv,
    output logic       do_load,
    output logic       do_step,
    output seq_state_t state_o
);

    seq_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_any) state_d = ST_RUN;
            ST_RUN:  begin
                if (start_any)  state_d = ST_RUN;
                else if (adv)   state_d = ST_RUN;
                else            state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (start_any || adv) state_d = ST_RUN;
                else                  state_d = ST_HOLD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs: load wins over advance; no stepping before a burst exists
    always_comb begin
        do_load = 1'b0;
        do_step = 1'b0;
        unique case (state_q)
            ST_IDLE: do_load = start_any;
            ST_RUN, ST_HOLD: begin
                do_load = start_any;
                do_step = adv && !start_any;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/burst_seq_lowgen.sv
module burst_seq_lowgen
    import burst_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_load,
    input  logic             do_step,
    input  logic             mode_i,
    input  logic [LOW_W-1:0] start_low,
    output logic [LOW_W-1:0] low_o,
    output order_t           order_o
);

    logic [LOW_W-1:0] base_q;
    logic [LOW_W-1:0] beat_q;
    order_t           order_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            beat_q  <= '0;
            order_q <= ORD_ILV;
        end else if (do_load) begin
            base_q  <= start_low;
            beat_q  <= '0;
            order_q <= mode_i ? ORD_ILV : ORD_LIN;
        end else if (do_step) begin
            beat_q  <= beat_q + 1'b1;
        end
    end

    assign low_o   = beat_low(base_q, beat_q, order_q);
    assign order_o = order_q;

endmodule

// File: rtl/burst_seq_upper.sv
module burst_seq_upper #(
    parameter int UP_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            do_load,
    input  logic [UP_W-1:0] up_i,
    output logic [UP_W-1:0] up_o
);

    logic [UP_W-1:0] up_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       up_q <= '0;
        else if (do_load) up_q <= up_i;
    end

    assign up_o = up_q;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_cpu_i,
    input  logic              start_ctl_i,
    input  logic              adv_i,
    input  logic              ilv_mode_i,
    input  logic [ADDR_W-1:0] ext_addr_i,
    output logic [ADDR_W-1:0] burst_addr_o
);

    localparam int UP_W = ADDR_W - LOW_W;

    logic             start_any;
    logic             do_load;
    logic             do_step;
    seq_state_t       state;
    logic [LOW_W-1:0] low;
    logic [UP_W-1:0]  up;
    order_t           order;

    assign start_any = start_cpu_i | start_ctl_i;

    burst_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_any(start_any),
        .adv      (adv_i),
        .do_load  (do_load),
        .do_step  (do_step),
        .state_o  (state)
    );

    burst_seq_lowgen u_low (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_load  (do_load),
        .do_step  (do_step),
        .mode_i   (ilv_mode_i),
        .start_low(ext_addr_i[LOW_W-1:0]),
        .low_o    (low),
        .order_o  (order)
    );

    burst_seq_upper #(.UP_W(UP_W)) u_up (
        .clk    (clk),
        .rst_n  (rst_n),
        .do_load(do_load),
        .up_i   (ext_addr_i[ADDR_W-1:LOW_W]),
        .up_o   (up)
    );

    assign burst_addr_o = {up, low};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_cpu_i,
    input logic              start_ctl_i,
    input logic              adv_i,
    input logic [ADDR_W-1:0] ext_addr_i,
    input logic [ADDR_W-1:0] burst_addr_o,
    input seq_state_t        state,
    input order_t            order
);

    logic ld;
    assign ld = start_cpu_i | start_ctl_i;

    // R2
    load_takes_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> burst_addr_o == $past(ext_addr_i));

    // R5
    upper_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> burst_addr_o[ADDR_W-1:2] == $past(burst_addr_o[ADDR_W-1:2]));

    // R6
    suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !adv_i) |=> $stable(burst_addr_o));

    // R3
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && adv_i && state != ST_IDLE && order == ORD_LIN)
        |=> burst_addr_o[1:0] == $past(burst_addr_o[1:0]) + 2'd1);

    // R4
    ilv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && adv_i && state != ST_IDLE && order == ORD_ILV)
        |=> burst_addr_o[0] != $past(burst_addr_o[0]));

    // R1
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !ld) |=> burst_addr_o == '0);

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_cpu_i (start_cpu_i),
    .start_ctl_i (start_ctl_i),
    .adv_i       (adv_i),
    .ext_addr_i  (ext_addr_i),
    .burst_addr_o(burst_addr_o),
    .state       (state),
    .order       (order)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start_cpu_i, start_ctl_i, adv_i, ilv_mode_i;
    logic [W-1:0] ext_addr_i;
    logic [W-1:0] burst_addr_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    burst_addr_seq #(.ADDR_W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .start_cpu_i(start_cpu_i), .start_ctl_i(start_ctl_i),
        .adv_i(adv_i), .ilv_mode_i(ilv_mode_i),
        .ext_addr_i(ext_addr_i), .burst_addr_o(burst_addr_o)
    );

    // {cpu, ctl, adv, mode, addr[7:0], expected[7:0]}
    localparam logic [19:0] VEC [16] = '{
        {4'b1000, 8'hA5, 8'hA5},  // R2 cpu load, linear
        {4'b0010, 8'h00, 8'hA6},  // R3
        {4'b0010, 8'h00, 8'hA7},  // R3
        {4'b0010, 8'h00, 8'hA4},  // R3 wrap
        {4'b0010, 8'h00, 8'hA5},  // R9
        {4'b0101, 8'h3E, 8'h3E},  // R2 ctl load, interleaved
        {4'b0011, 8'h00, 8'h3F},  // R4
        {4'b0001, 8'h00, 8'h3F},  // R6 suspend
        {4'b0011, 8'h00, 8'h3C},  // R4 resume
        {4'b0011, 8'h00, 8'h3D},  // R4
        {4'b1011, 8'h71, 8'h71},  // R7 load beats advance
        {4'b0010, 8'h00, 8'h70},  // R8 mode now 0, still interleaved
        {4'b0010, 8'hFF, 8'h73},  // R5 ext addr ignored
        {4'b1100, 8'hC3, 8'hC3},  // R2 both strobes
        {4'b0010, 8'h00, 8'hC0},  // R3
        {4'b0010, 8'h00, 8'hC1}   // R3
    };

    task automatic check(input logic [W-1:0] exp, input string req);
        checks++;
        if (burst_addr_o !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, burst_addr_o, exp);
        end
    endtask

    task automatic step(input logic cp, input logic ct, input logic av,
                        input logic md, input logic [W-1:0] a);
        @(negedge clk);
        start_cpu_i = cp; start_ctl_i = ct; adv_i = av;
        ilv_mode_i = md; ext_addr_i = a;
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        start_cpu_i = 0; start_ctl_i = 0; adv_i = 0; ilv_mode_i = 1; ext_addr_i = '0;
        repeat (3) @(posedge clk);
        #2 check(8'h00, "R1 reset");
        step(0, 0, 0, 1, 8'h00);
        rst_n = 1'b1;
        step(0, 0, 1, 1, 8'h55);
        check(8'h00, "R1 advance in idle");
        step(0, 0, 1, 0, 8'hAA);
        check(8'h00, "R1 advance in idle");

        foreach (VEC[i]) begin
            step(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15:8]);
            check(VEC[i][7:0], $sformatf("R2-R8 vector %0d", i));
        end

        // every start value, both orders, full wrap (R3 R4 R9)
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                logic [W-1:0] a;
                a = {6'h2B, 2'(s)};
                step(1, 0, 0, 1'(m), a);
                check(a, "R2 start");
                for (int k = 1; k <= 4; k++) begin
                    logic [1:0] lo;
                    lo = (m == 0) ? 2'(s + k) : 2'(s ^ (k % 4));
                    step(0, 0, 1, 1'(m), 8'h00);
                    check({6'h2B, lo}, (m == 0) ? "R3/R9 linear" : "R4/R9 interleaved");
                end
            end
        end

        // long suspend keeps value (R6)
        step(0, 1, 0, 0, 8'h12);
        step(0, 0, 1, 0, 8'h00);
        repeat (5) begin
            step(0, 0, 0, 1, 8'hFF);
            check(8'h13, "R6 hold");
        end
        step(0, 0, 1, 0, 8'h00);
        check(8'h10, "R6 resume");

        // reset mid-burst (R1)
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #2;
        check(8'h00, "R1 reset mid-burst");
        @(negedge clk) rst_n = 1'b1;
        step(0, 0, 1, 0, 8'h77);
        check(8'h00, "R1 idle after reset");

        finish_run();
    end

endmodule